// File: doc/BRIEF.md
# Console Device Register Set

This block sits on a 16-bit processor bus and makes a character keyboard and a character display look like a few memory locations. Software reaches it with ordinary loads and stores. Each device has a status word and a data word. The top bit of each status word is a ready flag that the hardware sets and clears by itself as the processor polls and transfers characters. A fifth location holds a machine control word, whose top bit enables the processor clock.

The bus port is single-cycle. An access is presented with `bus_en`, `bus_we`, an address and write data. The block answers within the same cycle with `bus_sel` and combinational read data. When `bus_sel` is low, the access belongs to external memory.

Characters arrive from the keyboard on a valid/ready stream. `kb_ready` is tied high, so the keyboard is never back-pressured. A character that arrives before the last one was read replaces it and sets a sticky overrun flag. Characters leave for the display on a valid/ready stream. `disp_valid` stays high and `disp_data` stays stable until the display raises `disp_ready`, which completes the transfer in that cycle.

Top module: `console_mmio`

## Requirements
- R1: After reset, the keyboard status word reads 0x0000 and keyboard data reads 0x0000. Display status reads 0x8000 and control reads 0x8000. `disp_valid` is 0, `kb_overrun` is 0, `clk_run` is 1 and `kb_ready` is 1.
- R2: `bus_sel` is high exactly when `bus_en` is high and the address is one of 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status), 0xFE06 (display data) or 0xFFFE (control). Every address bit is decoded. `bus_rdata` is 0 whenever `bus_sel` is low or `bus_we` is high.
- R3: A cycle with `kb_valid` high stores `kb_data`. From the next cycle, keyboard status reads 0x8000 (bit 15 = ready) and keyboard data reads the character zero-extended in bits 7:0.
- R4: A read of keyboard data clears the keyboard ready flag from the next cycle on. A read of keyboard status leaves it unchanged.
- R5: A character that arrives while the ready flag is set, and in a cycle that does not read keyboard data, overwrites the stored character and sets `kb_overrun`. `kb_overrun` stays set until reset. If a character arrives in the same cycle as a keyboard data read, the read returns the old character, the new character is stored, ready stays set and no overrun is recorded.
- R6: A write to display data while the display is idle drives `disp_data` with write data bits 7:0 and raises `disp_valid` from the next cycle. Display status then reads 0x0000.
- R7: While `disp_valid` is high and `disp_ready` is low, `disp_valid` and `disp_data` hold. A cycle with both high ends the transfer: from the next cycle `disp_valid` is 0 and display status reads 0x8000.
- R8: A write to display data while `disp_valid` is high is dropped. This includes the cycle in which the display accepts.
- R9: Writes to keyboard status, keyboard data and display status change nothing.
- R10: Write data bit 15 of a control write sets bit 15 of the control word and `clk_run` from the next cycle. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a store |
| bus_addr | input | 16 | Word address of the access |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Load data, combinational |
| bus_sel | output | 1 | This block claims the access |
| kb_valid | input | 1 | Keyboard character present |
| kb_data | input | 8 | Keyboard character |
| kb_ready | output | 1 | Always high: keyboard never stalled |
| kb_overrun | output | 1 | Sticky: a character was lost |
| disp_valid | output | 1 | Character waiting for the display |
| disp_data | output | 8 | Character for the display |
| disp_ready | input | 1 | Display accepts the character |
| clk_run | output | 1 | Control word bit 15, clock enable |

## Verification
The decoder is swept over two 16-address windows around the register addresses and over three aliases that differ only in high address bits. This separates full decode from partial decode. All 256 keyboard codes and all 256 display codes pass through a store, poll and clear round trip, so any stuck or swapped data bit shows up. The round trip on the display side also includes a blocked second store and a held stream. Two patterns are run back to back: a strobe that coincides with a data read, and a strobe with no read between. The first pattern must not count as an overrun and the second must. Stores to the read-only words and to the control word are checked by reading the state back.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA,
    SEL_MCTL
  } reg_sel_e;
endpackage

// File: rtl/console_decode.sv
module console_decode
  import console_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] KSTAT_A = 16'hFE00,
  parameter logic [AW-1:0] KDATA_A = 16'hFE02,
  parameter logic [AW-1:0] DSTAT_A = 16'hFE04,
  parameter logic [AW-1:0] DDATA_A = 16'hFE06,
  parameter logic [AW-1:0] MCTL_A  = 16'hFFFE
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    sel = SEL_NONE;
    if (en) begin
      if (addr == KSTAT_A)      sel = SEL_KSTAT;
      else if (addr == KDATA_A) sel = SEL_KDATA;
      else if (addr == DSTAT_A) sel = SEL_DSTAT;
      else if (addr == DDATA_A) sel = SEL_DDATA;
      else if (addr == MCTL_A)  sel = SEL_MCTL;
    end
  end
endmodule

// File: rtl/console_kbd.sv
module console_kbd #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_char,
  input  logic          take,
  output logic          full,
  output logic [CW-1:0] held,
  output logic          lost
);
  // A new character wins over a same-cycle read; it only counts as lost
  // when the previous one was still unread and not being read now.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
      lost <= 1'b0;
    end else begin
      if (in_valid) begin
        held <= in_char;
        full <= 1'b1;
        if (full && !take) lost <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/console_disp.sv
module console_disp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wr_char,
  output logic          out_valid,
  output logic [CW-1:0] out_char,
  input  logic          out_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_char  <= '0;
    end else if (out_valid) begin
      if (out_ready) out_valid <= 1'b0;
    end else if (wr) begin
      out_valid <= 1'b1;
      out_char  <= wr_char;
    end
  end
endmodule

// File: rtl/console_mctl.sv
module console_mctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_bit,
  output logic run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  run <= 1'b1;
    else if (wr) run <= wr_bit;
  end
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] KSTAT_A = 16'hFE00,
  parameter logic [AW-1:0] KDATA_A = 16'hFE02,
  parameter logic [AW-1:0] DSTAT_A = 16'hFE04,
  parameter logic [AW-1:0] DDATA_A = 16'hFE06,
  parameter logic [AW-1:0] MCTL_A  = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_sel,
  input  logic          kb_valid,
  input  logic [CW-1:0] kb_data,
  output logic          kb_ready,
  output logic          kb_overrun,
  output logic          disp_valid,
  output logic [CW-1:0] disp_data,
  input  logic          disp_ready,
  output logic          clk_run
);
  localparam int FLAG = DW - 1;
  localparam int PADW = DW - CW;

  reg_sel_e      sel;
  logic          kbd_full;
  logic [CW-1:0] kbd_char;
  logic          rd, wr;

  wire unused_wbits = ^bus_wdata[FLAG-1:CW];

  console_decode #(
    .AW(AW), .KSTAT_A(KSTAT_A), .KDATA_A(KDATA_A),
    .DSTAT_A(DSTAT_A), .DDATA_A(DDATA_A), .MCTL_A(MCTL_A)
  ) dec_i (.en(bus_en), .addr(bus_addr), .sel(sel));

  assign rd       = !bus_we;
  assign wr       = bus_we;
  assign bus_sel  = (sel != SEL_NONE);
  assign kb_ready = 1'b1;

  console_kbd #(.CW(CW)) kbd_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(kb_valid), .in_char(kb_data),
    .take((sel == SEL_KDATA) && rd),
    .full(kbd_full), .held(kbd_char), .lost(kb_overrun)
  );

  console_disp #(.CW(CW)) disp_i (
    .clk(clk), .rst_n(rst_n),
    .wr((sel == SEL_DDATA) && wr), .wr_char(bus_wdata[CW-1:0]),
    .out_valid(disp_valid), .out_char(disp_data), .out_ready(disp_ready)
  );

  console_mctl mctl_i (
    .clk(clk), .rst_n(rst_n),
    .wr((sel == SEL_MCTL) && wr), .wr_bit(bus_wdata[FLAG]),
    .run(clk_run)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_KSTAT: bus_rdata[FLAG] = kbd_full;
        SEL_KDATA: bus_rdata = {{PADW{1'b0}}, kbd_char};
        SEL_DSTAT: bus_rdata[FLAG] = !disp_valid;
        SEL_MCTL:  bus_rdata[FLAG] = clk_run;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] KDATA_A = 16'hFE02,
  parameter logic [AW-1:0] DDATA_A = 16'hFE06,
  parameter logic [AW-1:0] MCTL_A  = 16'hFFFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          wbit,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_sel,
  input logic          kb_valid,
  input logic [CW-1:0] kb_data,
  input logic          kb_overrun,
  input logic          kbd_full,
  input logic [CW-1:0] kbd_char,
  input logic          disp_valid,
  input logic [CW-1:0] disp_data,
  input logic          disp_ready,
  input logic          clk_run
);
  logic kread, dwrite, cwrite;
  assign kread  = bus_en && !bus_we && (bus_addr == KDATA_A);
  assign dwrite = bus_en && bus_we && (bus_addr == DDATA_A);
  assign cwrite = bus_en && bus_we && (bus_addr == MCTL_A);

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
  assert_char_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> (kbd_full && kbd_char == $past(kb_data)));
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kread && !kb_valid) |=> !kbd_full);
  assert_sticky_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kb_overrun |=> kb_overrun);
  assert_hold_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_data)));
  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !disp_valid);
  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && dwrite) |=> $stable(disp_data));
  assert_ctrl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cwrite |=> (clk_run == $past(wbit)));
endmodule

bind console_mmio console_mmio_chk #(
  .AW(AW), .DW(DW), .CW(CW),
  .KDATA_A(KDATA_A), .DDATA_A(DDATA_A), .MCTL_A(MCTL_A)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .wbit(bus_wdata[DW-1]), .bus_rdata(bus_rdata),
  .bus_sel(bus_sel), .kb_valid(kb_valid), .kb_data(kb_data),
  .kb_overrun(kb_overrun), .kbd_full(kbd_full), .kbd_char(kbd_char),
  .disp_valid(disp_valid), .disp_data(disp_data),
  .disp_ready(disp_ready), .clk_run(clk_run)
);

// File: tb/console_mmio_tb_top.sv
module console_mmio_tb_top;
  localparam logic [15:0] A_KS = 16'hFE00, A_KD = 16'hFE02,
                          A_DS = 16'hFE04, A_DD = 16'hFE06, A_MC = 16'hFFFE;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_sel, kb_valid = 0, kb_ready, kb_overrun, disp_valid, disp_ready = 0, clk_run;
  logic [7:0] kb_data = 0, disp_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  console_mmio dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_sel(bus_sel), .kb_valid(kb_valid), .kb_data(kb_data),
    .kb_ready(kb_ready), .kb_overrun(kb_overrun), .disp_valid(disp_valid),
    .disp_data(disp_data), .disp_ready(disp_ready), .clk_run(clk_run)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle, optionally with a keyboard strobe; read data sampled before the edge.
  task automatic step(input logic en, input logic we, input logic [15:0] a,
                      input logic [15:0] wd, input logic kv, input logic [7:0] kd,
                      output logic [15:0] rdat, output logic sel);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
    kb_valid = kv; kb_data = kd;
    #1 rdat = bus_rdata; sel = bus_sel;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0; kb_valid = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    logic s;
    step(1, 0, a, 16'h0, 0, 8'h0, d, s);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] r; logic s;
    step(1, 1, a, d, 0, 8'h0, r, s);
  endtask

  task automatic key(input logic [7:0] c);
    logic [15:0] r; logic s;
    step(0, 0, 16'h0, 16'h0, 1, c, r, s);
  endtask

  task automatic ack();
    @(negedge clk); disp_ready = 1;
    @(posedge clk); #1 disp_ready = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %h expected %h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic s;
    do_reset();
    // R1 reset state
    rd(A_KS, d); chk("R1 kstat", d, 16'h0000);
    rd(A_KD, d); chk("R1 kdata", d, 16'h0000);
    rd(A_DS, d); chk("R1 dstat", d, 16'h8000);
    rd(A_MC, d); chk("R1 mctl", d, 16'h8000);
    chk("R1 disp_valid", {15'h0, disp_valid}, 16'h0);
    chk("R1 overrun", {15'h0, kb_overrun}, 16'h0);
    chk("R1 clk_run", {15'h0, clk_run}, 16'h1);
    chk("R1 kb_ready", {15'h0, kb_ready}, 16'h1);

    // R2 decode sweep: two windows plus high-bit aliases
    for (int i = 0; i < 35; i++) begin
      logic [15:0] a; logic hit;
      a = (i < 16) ? 16'hFE00 + 16'(i) : (i < 32) ? 16'hFFF0 + 16'(i - 16)
        : (i == 32) ? 16'h7E00 : (i == 33) ? 16'hBE06 : 16'h7FFE;
      hit = (a == A_KS) || (a == A_KD) || (a == A_DS) || (a == A_DD) || (a == A_MC);
      step(1, 0, a, 16'h0, 0, 8'h0, d, s);
      chk("R2 sel", {15'h0, s}, {15'h0, hit});
      if (!hit) chk("R2 rdata idle", d, 16'h0);
    end
    step(0, 0, A_MC, 16'h0, 0, 8'h0, d, s);
    chk("R2 sel without en", {15'h0, s}, 16'h0);
    step(1, 1, A_KS, 16'h0, 0, 8'h0, d, s);
    chk("R2 rdata on write", d, 16'h0);

    // R3/R4 keyboard sweep over all codes
    for (int c = 0; c < 256; c++) begin
      key(8'(c));
      rd(A_KS, d); chk("R3 ready set", d, 16'h8000);
      rd(A_KS, d); chk("R4 status read keeps", d, 16'h8000);
      rd(A_KD, d); chk("R3 char", d, 16'(c));
      rd(A_KS, d); chk("R4 cleared", d, 16'h0000);
    end
    chk("R5 no overrun after sweep", {15'h0, kb_overrun}, 16'h0);

    // R5 strobe coinciding with data read
    key(8'h41);
    step(1, 0, A_KD, 16'h0, 1, 8'h42, d, s);
    chk("R5 same-cycle read old", d, 16'h0041);
    rd(A_KS, d); chk("R5 ready kept", d, 16'h8000);
    rd(A_KD, d); chk("R5 new char", d, 16'h0042);
    chk("R5 no overrun", {15'h0, kb_overrun}, 16'h0);
    // R5 strobe with no read between
    key(8'h10); key(8'h20);
    chk("R5 overrun set", {15'h0, kb_overrun}, 16'h1);
    rd(A_KD, d); chk("R5 overwrite", d, 16'h0020);
    repeat (3) @(posedge clk);
    #1 chk("R5 overrun sticky", {15'h0, kb_overrun}, 16'h1);
    do_reset();

    // R6/R7/R8 display sweep
    for (int c = 0; c < 256; c++) begin
      wr(A_DD, {8'hA5, 8'(c)});
      chk("R6 valid", {15'h0, disp_valid}, 16'h1);
      chk("R6 data", {8'h0, disp_data}, 16'(c));
      rd(A_DS, d); chk("R6 busy", d, 16'h0000);
      wr(A_DD, {8'h0, ~8'(c)});
      chk("R8 dropped", {8'h0, disp_data}, 16'(c));
      chk("R7 held", {15'h0, disp_valid}, 16'h1);
      ack();
      chk("R7 released", {15'h0, disp_valid}, 16'h0);
      rd(A_DS, d); chk("R7 ready again", d, 16'h8000);
    end
    // R8 write in the accept cycle is dropped
    wr(A_DD, 16'h0055);
    @(negedge clk); disp_ready = 1; bus_en = 1; bus_we = 1;
    bus_addr = A_DD; bus_wdata = 16'h0066;
    @(posedge clk); #1 disp_ready = 0; bus_en = 0; bus_we = 0;
    chk("R8 accept-cycle write", {15'h0, disp_valid}, 16'h0);
    chk("R8 accept-cycle data", {8'h0, disp_data}, 16'h0055);

    // R9 writes to read-only words
    wr(A_KS, 16'hFFFF); wr(A_KD, 16'hFFFF); wr(A_DS, 16'h0000);
    rd(A_KS, d); chk("R9 kstat", d, 16'h0000);
    rd(A_KD, d); chk("R9 kdata", d, 16'h0000);
    rd(A_DS, d); chk("R9 dstat", d, 16'h8000);
    chk("R9 disp idle", {15'h0, disp_valid}, 16'h0);

    // R10 control word
    wr(A_MC, 16'h7FFF);
    chk("R10 clk_run low", {15'h0, clk_run}, 16'h0);
    rd(A_MC, d); chk("R10 mctl cleared", d, 16'h0000);
    wr(A_MC, 16'hFFFF);
    chk("R10 clk_run high", {15'h0, clk_run}, 16'h1);
    rd(A_MC, d); chk("R10 other bits zero", d, 16'h8000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule